// File: doc/BRIEF.md
# Vector Memory Instruction Legality Checker

This block decides, in a single combinational pass, whether a decoded vector memory instruction or vector atomic instruction may issue under the vector configuration currently in force. It sits beside the decoder. It takes the configuration state (an invalid-configuration flag, the element-width code and the register-grouping code), the presence of the atomic extension, and the fields of the decoded instruction. It returns a legal flag and a cause code that names the first rule that failed.

The rules cover several areas. A register specifier must be aligned to its group. A widened destination must fit the grouping limit. A masked load must not write over the mask register. A segment access must not use more than eight registers. The memory element width must be compatible with the element width, and atomics must stay inside the SEW bounds set by XLEN. Decoding, address generation, memory access and vector-length computation are done elsewhere.

Top module: `vec_legal_chk`

## Requirements
- R1: While `cfg_bad` is 1, every instruction is illegal with cause 1. This check has the highest priority.
- R2: `op_class` is encoded as follows: 0 unit-stride load, 1 strided load, 2 indexed load, 3 fault-only-first load, 4 unit-stride store, 5 strided store, 6 indexed store, 7 atomic. An atomic (class 7) with `amo_ext` 0 gives cause 2. `amo_ext` has no effect on any other class.
- R3: `sew_code` 0..3 selects 8, 16, 32 or 64 bits. `mem_width` 0..3 selects byte, halfword, word or SEW-sized element. For classes 0..6, a halfword element with SEW code 0 gives cause 3, and a word element with SEW code 0 or 1 gives cause 3. Byte and SEW-sized elements always pass this check.
- R4: For an atomic, SEW in bytes must be at least 4 and at most XLEN/8, otherwise the cause is 3. `mem_width` is ignored for atomics.
- R5: With grouping code n, `vd` must be a multiple of 2^n, otherwise the cause is 4.
- R6: With `dst_widen` 1, `vd` must be a multiple of 2^(n+1). With `dst_widen` 1 and n = 3, the instruction is always cause 4.
- R7: Indexed classes (2 and 6) and atomics also require `vs2` to be a multiple of 2^n (never widened), otherwise the cause is 4. Other classes ignore `vs2`.
- R8: A load (classes 0..3) with `vm` 0 and `vd` 0 gives cause 5. The exception is n = 0 with `ovl_strict` 0. With `ovl_strict` 1, the overlap is illegal even at n = 0.
- R9: Stores never fail the overlap check. An atomic is subject to it only when `wd` is 1.
- R10: For classes 0..6, `nfields` × 2^n greater than 8 gives cause 6. Atomics ignore `nfields`.
- R11: When several rules fail, the cause is the first failing rule in this order: 1 configuration, 2 extension, 3 width, 4 alignment, 5 overlap, 6 segment.
- R12: `legal` is 1 exactly when `cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_bad | input | 1 | Current vector configuration is invalid |
| sew_code | input | 2 | Element width code (8 << code bits) |
| lmul_code | input | 2 | Register grouping code n (group of 2^n) |
| amo_ext | input | 1 | Atomic extension present |
| op_class | input | 3 | Instruction class, encoded as in R2 |
| mem_width | input | 2 | Memory element width code |
| vm | input | 1 | Unmasked when 1 |
| wd | input | 1 | Atomic writes its old value back to vd |
| dst_widen | input | 1 | Destination group is widened |
| ovl_strict | input | 1 | Forbid mask overlap even at n = 0 |
| nfields | input | NF_W | Segment field count |
| vd | input | REG_W | Destination or store-data specifier |
| vs2 | input | REG_W | Index register specifier |
| legal | output | 1 | Instruction may issue |
| cause | output | 3 | First failing rule, 0 when legal |

## Verification
The assertions are checked on every input change. They cover these properties: an invalid configuration always reports cause 1; an atomic without the extension reports cause 2 when the configuration is valid; a store never reports an overlap; an atomic never reports a segment fault; and a legal result always has an aligned `vd` and never a widened destination at n = 3. Only the bench scenarios can show the exact cause in each priority collision. They also cover the boundary cases: the n = 0 overlap exception with and without the strict flag, `nfields` × 2^n equal to 8 against 10 or 12, atomic SEW at each edge, and indexed alignment of `vs2` compared with classes that ignore `vs2`.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    typedef enum logic [2:0] {
        CLS_LD_UNIT   = 3'd0,
        CLS_LD_STRIDE = 3'd1,
        CLS_LD_INDEX  = 3'd2,
        CLS_LD_FF     = 3'd3,
        CLS_ST_UNIT   = 3'd4,
        CLS_ST_STRIDE = 3'd5,
        CLS_ST_INDEX  = 3'd6,
        CLS_ATOMIC    = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        CZ_NONE    = 3'd0,
        CZ_CONFIG  = 3'd1,
        CZ_EXT     = 3'd2,
        CZ_WIDTH   = 3'd3,
        CZ_ALIGN   = 3'd4,
        CZ_OVERLAP = 3'd5,
        CZ_SEGMENT = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        MW_BYTE = 2'd0,
        MW_HALF = 2'd1,
        MW_WORD = 2'd2,
        MW_ELEM = 2'd3
    } mem_width_e;

endpackage

// File: rtl/vlc_group_align.sv
module vlc_group_align #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] reg_idx,
    input  logic [1:0]       lmul_code,
    input  logic             widen,
    output logic             ok
);
    localparam logic [REG_W-1:0] ALL_ONES = {REG_W{1'b1}};

    logic [2:0]       shift;
    logic [REG_W-1:0] low_mask;
    logic             widen_over;

    always_comb begin
        shift      = {1'b0, lmul_code} + {2'b00, widen};
        low_mask   = ~(ALL_ONES << shift);
        widen_over = widen && (lmul_code == 2'd3);
        ok         = !widen_over && ((reg_idx & low_mask) == '0);
    end
endmodule

// File: rtl/vlc_width_rule.sv
module vlc_width_rule
    import vlc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic       is_atomic,
    input  logic [1:0] sew_code,
    input  logic [1:0] mem_width,
    output logic       ok
);
    localparam int         SEW_TOP_I = $clog2(XLEN / 8);
    localparam logic [1:0] SEW_TOP   = 2'(SEW_TOP_I);
    localparam logic [1:0] SEW_LOW   = 2'd2;

    logic mem_ok;
    logic amo_ok;

    always_comb begin
        unique case (mem_width_e'(mem_width))
            MW_BYTE: mem_ok = 1'b1;
            MW_HALF: mem_ok = (sew_code != 2'd0);
            MW_WORD: mem_ok = (sew_code >= 2'd2);
            MW_ELEM: mem_ok = 1'b1;
            default: mem_ok = 1'b0;
        endcase
        amo_ok = (sew_code >= SEW_LOW) && (sew_code <= SEW_TOP);
        ok     = is_atomic ? amo_ok : mem_ok;
    end
endmodule

// File: rtl/vlc_mask_overlap.sv
module vlc_mask_overlap (
    input  logic       applies,
    input  logic       vm,
    input  logic       vd_zero,
    input  logic [1:0] lmul_code,
    input  logic       strict,
    output logic       ok
);
    logic hits_mask;
    logic exempt;

    always_comb begin
        hits_mask = !vm && vd_zero;
        exempt    = (lmul_code == 2'd0) && !strict;
        ok        = !applies || !hits_mask || exempt;
    end
endmodule

// File: rtl/vlc_segment_limit.sv
module vlc_segment_limit #(
    parameter int NF_W     = 4,
    parameter int MAX_REGS = 8
) (
    input  logic            applies,
    input  logic [NF_W-1:0] nfields,
    input  logic [1:0]      lmul_code,
    output logic            ok
);
    localparam int PW = NF_W + 3;
    localparam logic [PW-1:0] LIMIT = PW'(MAX_REGS);

    logic [PW-1:0] regs_used;

    always_comb begin
        regs_used = {3'b000, nfields} << lmul_code;
        ok        = !applies || (regs_used <= LIMIT);
    end
endmodule

// File: rtl/vec_legal_chk.sv
module vec_legal_chk
    import vlc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5,
    parameter int NF_W  = 4
) (
    input  logic             cfg_bad,
    input  logic [1:0]       sew_code,
    input  logic [1:0]       lmul_code,
    input  logic             amo_ext,
    input  logic [2:0]       op_class,
    input  logic [1:0]       mem_width,
    input  logic             vm,
    input  logic             wd,
    input  logic             dst_widen,
    input  logic             ovl_strict,
    input  logic [NF_W-1:0]  nfields,
    input  logic [REG_W-1:0] vd,
    input  logic [REG_W-1:0] vs2,
    output logic             legal,
    output logic [2:0]       cause
);
    localparam int NSPEC = 2;

    op_class_e cls;
    logic is_load, is_store, is_index, is_atomic;
    logic need_vs2, ovl_applies, seg_applies;
    logic ext_ok, width_ok, ovl_ok, seg_ok, align_all;

    logic [REG_W-1:0] spec_idx   [NSPEC];
    logic             spec_widen [NSPEC];
    logic             spec_used  [NSPEC];
    logic             spec_ok    [NSPEC];

    always_comb begin
        cls         = op_class_e'(op_class);
        is_load     = (cls == CLS_LD_UNIT) || (cls == CLS_LD_STRIDE) ||
                      (cls == CLS_LD_INDEX) || (cls == CLS_LD_FF);
        is_store    = (cls == CLS_ST_UNIT) || (cls == CLS_ST_STRIDE) ||
                      (cls == CLS_ST_INDEX);
        is_index    = (cls == CLS_LD_INDEX) || (cls == CLS_ST_INDEX);
        is_atomic   = (cls == CLS_ATOMIC);
        need_vs2    = is_index || is_atomic;
        ovl_applies = is_load || (is_atomic && wd);
        seg_applies = is_load || is_store;
        ext_ok      = !is_atomic || amo_ext;
    end

    always_comb begin
        spec_idx[0]   = vd;
        spec_widen[0] = dst_widen;
        spec_used[0]  = 1'b1;
        spec_idx[1]   = vs2;
        spec_widen[1] = 1'b0;
        spec_used[1]  = need_vs2;
    end

    for (genvar g = 0; g < NSPEC; g++) begin : g_spec
        vlc_group_align #(.REG_W(REG_W)) u_align (
            .reg_idx   (spec_idx[g]),
            .lmul_code (lmul_code),
            .widen     (spec_widen[g]),
            .ok        (spec_ok[g])
        );
    end

    always_comb begin
        align_all = 1'b1;
        for (int i = 0; i < NSPEC; i++) begin
            if (spec_used[i] && !spec_ok[i]) align_all = 1'b0;
        end
    end

    vlc_width_rule #(.XLEN(XLEN)) u_width (
        .is_atomic (is_atomic),
        .sew_code  (sew_code),
        .mem_width (mem_width),
        .ok        (width_ok)
    );

    vlc_mask_overlap u_overlap (
        .applies   (ovl_applies),
        .vm        (vm),
        .vd_zero   (vd == '0),
        .lmul_code (lmul_code),
        .strict    (ovl_strict),
        .ok        (ovl_ok)
    );

    vlc_segment_limit #(.NF_W(NF_W), .MAX_REGS(8)) u_segment (
        .applies   (seg_applies),
        .nfields   (nfields),
        .lmul_code (lmul_code),
        .ok        (seg_ok)
    );

    cause_e first_fail;

    always_comb begin
        if (cfg_bad)         first_fail = CZ_CONFIG;
        else if (!ext_ok)    first_fail = CZ_EXT;
        else if (!width_ok)  first_fail = CZ_WIDTH;
        else if (!align_all) first_fail = CZ_ALIGN;
        else if (!ovl_ok)    first_fail = CZ_OVERLAP;
        else if (!seg_ok)    first_fail = CZ_SEGMENT;
        else                 first_fail = CZ_NONE;
        cause = first_fail;
        legal = (first_fail == CZ_NONE);
    end
endmodule

// File: rtl/vec_legal_chk_sva.sv
module vec_legal_chk_sva #(
    parameter int REG_W = 5
) (
    input logic             cfg_bad,
    input logic             amo_ext,
    input logic [2:0]       op_class,
    input logic [1:0]       lmul_code,
    input logic             dst_widen,
    input logic [REG_W-1:0] vd,
    input logic             legal,
    input logic [2:0]       cause
);
    logic [REG_W-1:0] grp_mask;
    logic             is_store;

    always_comb begin
        grp_mask = ~({REG_W{1'b1}} << lmul_code);
        is_store = (op_class == 3'd4) || (op_class == 3'd5) || (op_class == 3'd6);

        // R1
        cfg_first_chk: assert (!cfg_bad || cause == 3'd1);
        // R2
        amo_ext_chk: assert (!(op_class == 3'd7 && !amo_ext && !cfg_bad) || cause == 3'd2);
        // R9
        store_no_overlap_chk: assert (!is_store || cause != 3'd5);
        // R10
        amo_no_segment_chk: assert (op_class != 3'd7 || cause != 3'd6);
        // R6
        widen_top_chk: assert (!legal || !(dst_widen && lmul_code == 2'd3));
        // R5
        vd_aligned_chk: assert (!legal || (vd & grp_mask) == '0);
    end
endmodule

bind vec_legal_chk vec_legal_chk_sva #(.REG_W(REG_W)) u_sva (
    .cfg_bad   (cfg_bad),
    .amo_ext   (amo_ext),
    .op_class  (op_class),
    .lmul_code (lmul_code),
    .dst_widen (dst_widen),
    .vd        (vd),
    .legal     (legal),
    .cause     (cause)
);

// File: tb/vec_legal_chk_tb.sv
module vec_legal_chk_tb;
    localparam int REG_W = 5;
    localparam int NF_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    typedef struct {
        logic             cfg_bad;
        logic [1:0]       sew;
        logic [1:0]       lmul;
        logic             ext;
        logic [2:0]       cls;
        logic [1:0]       mw;
        logic             vm;
        logic             wd;
        logic             widen;
        logic             strict;
        logic [NF_W-1:0]  nf;
        logic [REG_W-1:0] vd;
        logic [REG_W-1:0] vs2;
    } stim_t;

    typedef struct {
        logic [2:0] cause;
        string      tag;
    } exp_t;

    logic             cfg_bad, amo_ext, vm, wd, dst_widen, ovl_strict;
    logic [1:0]       sew_code, lmul_code, mem_width;
    logic [2:0]       op_class;
    logic [NF_W-1:0]  nfields;
    logic [REG_W-1:0] vd, vs2;
    logic             legal;
    logic [2:0]       cause;

    vec_legal_chk #(.XLEN(64), .REG_W(REG_W), .NF_W(NF_W)) u_dut (
        .cfg_bad(cfg_bad), .sew_code(sew_code), .lmul_code(lmul_code),
        .amo_ext(amo_ext), .op_class(op_class), .mem_width(mem_width),
        .vm(vm), .wd(wd), .dst_widen(dst_widen), .ovl_strict(ovl_strict),
        .nfields(nfields), .vd(vd), .vs2(vs2), .legal(legal), .cause(cause)
    );

    exp_t exp_q[$];
    int total = 0;
    int bad   = 0;
    bit drv_done = 0;

    function automatic stim_t base();
        stim_t s;
        s.cfg_bad = 0; s.sew = 2'd2; s.lmul = 2'd0; s.ext = 1;
        s.cls = 3'd0; s.mw = 2'd3; s.vm = 1; s.wd = 0; s.widen = 0;
        s.strict = 0; s.nf = 4'd1; s.vd = 5'd4; s.vs2 = 5'd8;
        return s;
    endfunction

    task automatic apply(stim_t s);
        cfg_bad = s.cfg_bad; sew_code = s.sew; lmul_code = s.lmul;
        amo_ext = s.ext; op_class = s.cls; mem_width = s.mw; vm = s.vm;
        wd = s.wd; dst_widen = s.widen; ovl_strict = s.strict;
        nfields = s.nf; vd = s.vd; vs2 = s.vs2;
    endtask

    task automatic send(stim_t s, logic [2:0] exp_cause, string tag);
        exp_t e;
        @(negedge clk);
        apply(s);
        e.cause = exp_cause;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares one expected item per clock, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (cause !== e.cause) begin
                    bad++;
                    $display("FAIL %s cause actual=%0d expected=%0d", e.tag, cause, e.cause);
                end
                total++;
                if (legal !== (e.cause == 3'd0)) begin
                    bad++;
                    $display("FAIL R12 (%s) legal actual=%0b expected=%0b",
                             e.tag, legal, (e.cause == 3'd0));
                end
            end
        end
    end

    initial begin
        stim_t s;
        apply(base());
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R12: clean configuration is legal
        s = base(); send(s, 3'd0, "R12 default");
        // R1: invalid configuration wins over misalignment
        s = base(); s.cfg_bad = 1; s.lmul = 2'd1; s.vd = 5'd3; send(s, 3'd1, "R1");
        // R2
        s = base(); s.cls = 3'd7; s.ext = 0; send(s, 3'd2, "R2 atomic no ext");
        s = base(); s.cls = 3'd0; s.ext = 0; send(s, 3'd0, "R2 load ignores ext");
        // R3
        s = base(); s.sew = 2'd0; s.mw = 2'd1; send(s, 3'd3, "R3 half at sew8");
        s = base(); s.sew = 2'd1; s.mw = 2'd2; send(s, 3'd3, "R3 word at sew16");
        s = base(); s.sew = 2'd1; s.mw = 2'd1; send(s, 3'd0, "R3 half at sew16");
        s = base(); s.sew = 2'd0; s.mw = 2'd0; send(s, 3'd0, "R3 byte at sew8");
        // R4
        s = base(); s.cls = 3'd7; s.sew = 2'd1; send(s, 3'd3, "R4 atomic sew16");
        s = base(); s.cls = 3'd7; s.sew = 2'd3; send(s, 3'd0, "R4 atomic sew64");
        s = base(); s.cls = 3'd7; s.sew = 2'd2; s.mw = 2'd1; send(s, 3'd0, "R4 atomic ignores mw");
        // R5
        s = base(); s.lmul = 2'd2; s.vd = 5'd4; send(s, 3'd0, "R5 aligned");
        s = base(); s.lmul = 2'd2; s.vd = 5'd6; send(s, 3'd4, "R5 misaligned");
        // R6
        s = base(); s.widen = 1; s.lmul = 2'd1; s.vd = 5'd2; send(s, 3'd4, "R6 widen misaligned");
        s = base(); s.widen = 1; s.lmul = 2'd1; s.vd = 5'd4; send(s, 3'd0, "R6 widen aligned");
        s = base(); s.widen = 1; s.lmul = 2'd3; s.vd = 5'd0; send(s, 3'd4, "R6 widen at lmul3");
        // R7
        s = base(); s.cls = 3'd2; s.lmul = 2'd1; s.vs2 = 5'd3; send(s, 3'd4, "R7 indexed load vs2");
        s = base(); s.cls = 3'd6; s.lmul = 2'd1; s.vs2 = 5'd3; send(s, 3'd4, "R7 indexed store vs2");
        s = base(); s.cls = 3'd0; s.lmul = 2'd1; s.vs2 = 5'd3; send(s, 3'd0, "R7 unit ignores vs2");
        // R8
        s = base(); s.cls = 3'd1; s.vm = 0; s.vd = 5'd0; s.lmul = 2'd1; send(s, 3'd5, "R8 overlap lmul1");
        s = base(); s.cls = 3'd3; s.vm = 0; s.vd = 5'd0; send(s, 3'd0, "R8 lmul0 exempt");
        s = base(); s.cls = 3'd3; s.vm = 0; s.vd = 5'd0; s.strict = 1; send(s, 3'd5, "R8 strict");
        // R9
        s = base(); s.cls = 3'd4; s.vm = 0; s.vd = 5'd0; s.lmul = 2'd1; s.strict = 1; send(s, 3'd0, "R9 store exempt");
        s = base(); s.cls = 3'd7; s.vm = 0; s.vd = 5'd0; s.lmul = 2'd1; send(s, 3'd0, "R9 atomic wd0");
        s = base(); s.cls = 3'd7; s.vm = 0; s.vd = 5'd0; s.lmul = 2'd1; s.wd = 1; send(s, 3'd5, "R9 atomic wd1");
        // R10
        s = base(); s.nf = 4'd4; s.lmul = 2'd1; send(s, 3'd0, "R10 nf4 lmul1");
        s = base(); s.nf = 4'd5; s.lmul = 2'd1; send(s, 3'd6, "R10 nf5 lmul1");
        s = base(); s.nf = 4'd3; s.lmul = 2'd2; send(s, 3'd6, "R10 nf3 lmul2");
        s = base(); s.cls = 3'd7; s.nf = 4'd8; s.lmul = 2'd1; send(s, 3'd0, "R10 atomic ignores nf");
        // R11
        s = base(); s.sew = 2'd0; s.mw = 2'd1; s.lmul = 2'd1; s.vd = 5'd1; send(s, 3'd3, "R11 width before align");
        s = base(); s.vm = 0; s.vd = 5'd0; s.lmul = 2'd1; s.nf = 4'd8; send(s, 3'd5, "R11 overlap before segment");
        s = base(); s.cls = 3'd7; s.ext = 0; s.sew = 2'd0; send(s, 3'd2, "R11 ext before width");

        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        drv_done = 1;
    end

    initial begin
        int cycles = 0;
        while (!drv_done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!drv_done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule